// File: doc/BRIEF.md
# Startup Reset Sequencer with Status Watchdog

This block gives a DAC controller and the signal generators that feed it a fixed, repeatable reset history after power-up. Nothing happens until the clock generator reports lock. The block then lets the system settle for a long, programmable interval. After that it fires a burst of active-low reset pulses at a fixed pitch. Once the burst is over it raises a done flag and watches two health flags from the DAC controller: its output-enable status and its data-valid status. If either flag drops, the block issues a further reset pulse. After each such pulse, monitoring pauses for a recovery interval.

An operator pushbutton can also request a pulse. The request fires when the button is let go, after debouncing, and only once the burst has finished. Losing clock lock at any time holds the reset line low and restarts the whole sequence from the settling interval. A running counter reports how many reset pulses have been issued since power-up. All intervals are counted in cycles of the 100 MHz system clock and are parameters. The defaults are about 5 s settling, 15 pulses at a 1 s pitch, 16-cycle pulses, a 100 ms recovery interval and a 20 ms debounce.

Top module: `boot_reset_seq`

## Requirements
- R1: While the synchronized lock input is low, `rstN` is 0 and `seqDone` is 0, and no pulse is counted; `resetCount` is 0 after power-up.
- R2: The first reset pulse begins between SETTLE_CYC and SETTLE_CYC+4 clock cycles after `lockIn` rises.
- R3: The burst contains exactly BURST_NUM pulses, whose falling edges are exactly SPACING_CYC cycles apart.
- R4: Every reset pulse holds `rstN` low for exactly PULSE_CYC cycles (PULSE_CYC must be at least 3).
- R5: `seqDone` is 0 during the burst. It becomes 1 in the cycle `rstN` returns high after the last burst pulse, and it stays 1 while lock holds.
- R6: After the burst, a low on `dacEnIn` or on `dataValidIn` (1 = healthy for both) causes one reset pulse; with both high, no pulse is issued.
- R7: After any pulse issued once the burst is done, status flags are ignored for HOLDOFF_CYC cycles. Pulse starts caused by a flag held low are therefore at least PULSE_CYC+HOLDOFF_CYC cycles apart.
- R8: A button press (`btnIn` = 1 is pressed) produces a pulse only after release, never while held. A release during the settling interval or the burst is ignored.
- R9: A button level that lasts fewer than DEB_CYC consecutive cycles is ignored.
- R10: When lock is lost, `rstN` goes low and `seqDone` goes low within 4 cycles. When lock returns, a complete new burst of BURST_NUM pulses follows.
- R11: `resetCount` increments by one at the start of every pulse (burst, status or button). The low hold caused by lock loss is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz system clock |
| lockIn | input | 1 | Clock-lock indication, asynchronous |
| btnIn | input | 1 | Operator pushbutton, 1 = pressed, asynchronous |
| dacEnIn | input | 1 | DAC output-enable status, 1 = healthy |
| dataValidIn | input | 1 | DAC data-valid status, 1 = healthy |
| rstN | output | 1 | Active-low reset to downstream logic |
| seqDone | output | 1 | Startup burst completed, lock held |
| resetCount | output | COUNT_W | Total reset pulses issued since power-up |

## Verification
The hardest situation to reach from the ports is a button release that lands inside the gap between two burst pulses. This release must not add a pulse or shift the burst pitch. The stimulus waits for the first pulse edge, then holds the button long enough to pass the debouncer, so that the debounced release falls in the gap. It then checks both the pulse count and the pitch. A status flag held low for many cycles is the second hard case: it shows whether the recovery interval truly spaces the repeated pulses.

// File: rtl/boot_reset_pkg.sv
package boot_reset_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PULSE,
    ST_GAP,
    ST_HOLDOFF,
    ST_MONITOR
  } seqState_e;

  typedef enum logic [1:0] {
    LEN_SETTLE,
    LEN_PULSE,
    LEN_GAP,
    LEN_HOLD
  } lenSel_e;

  typedef struct packed {
    logic    timerLoad;
    lenSel_e lenSel;
    logic    burstLoad;
    logic    burstDec;
    logic    countInc;
    logic    holdLow;
    logic    doneSet;
  } seqStrobe_t;

endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES] = '{default: '0};

  always_ff @(posedge clk) stage[0] <= asyncIn;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) stage[g] <= stage[g-1];
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/brs_debounce.sv
module brs_debounce #(
  parameter int DEB_CYC = 2_000_000
) (
  input  logic clk,
  input  logic enable,
  input  logic rawIn,
  output logic level,
  output logic releasePulse
);

  localparam int CNT_W = $clog2(DEB_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_CYC - 1);

  logic [CNT_W-1:0] stableCnt = '0;
  logic             levelReg  = 1'b0;
  logic             relReg    = 1'b0;
  logic             accept;

  assign accept = (rawIn != levelReg) && (stableCnt == LAST);

  always_ff @(posedge clk) begin
    if (!enable) begin
      stableCnt <= '0;
      levelReg  <= 1'b0;
      relReg    <= 1'b0;
    end else begin
      relReg <= accept && levelReg;
      if (rawIn == levelReg) begin
        stableCnt <= '0;
      end else if (accept) begin
        stableCnt <= '0;
        levelReg  <= rawIn;
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end

  assign level        = levelReg;
  assign releasePulse = relReg;

  // R9
  deb_settled_chk: assert property (@(posedge clk) disable iff (!enable)
    !$stable(levelReg) |-> (levelReg == $past(rawIn)));

endmodule

// File: rtl/brs_control.sv
module brs_control
  import boot_reset_pkg::*;
(
  input  logic       clk,
  input  logic       lockS,
  input  logic       enS,
  input  logic       validS,
  input  logic       btnRel,
  input  logic       timerZero,
  input  logic       burstEmpty,
  input  logic       doneFlag,
  output seqStrobe_t strobe
);

  seqState_e  state = ST_IDLE;
  seqState_e  nextState;
  seqStrobe_t str;

  always_comb begin
    nextState = state;
    str       = '0;
    unique case (state)
      ST_IDLE: begin
        if (lockS) begin
          nextState     = ST_SETTLE;
          str.timerLoad = 1'b1;
          str.lenSel    = LEN_SETTLE;
          str.burstLoad = 1'b1;
        end
      end
      ST_SETTLE, ST_GAP: begin
        if (timerZero) begin
          nextState     = ST_PULSE;
          str.timerLoad = 1'b1;
          str.lenSel    = LEN_PULSE;
          str.burstDec  = 1'b1;
          str.countInc  = 1'b1;
        end
      end
      ST_PULSE: begin
        if (timerZero) begin
          str.timerLoad = 1'b1;
          if (!doneFlag && !burstEmpty) begin
            nextState  = ST_GAP;
            str.lenSel = LEN_GAP;
          end else begin
            nextState   = ST_HOLDOFF;
            str.lenSel  = LEN_HOLD;
            str.doneSet = !doneFlag;
          end
        end
      end
      ST_HOLDOFF: begin
        if (btnRel) begin
          nextState     = ST_PULSE;
          str.timerLoad = 1'b1;
          str.lenSel    = LEN_PULSE;
          str.countInc  = 1'b1;
        end else if (timerZero) begin
          nextState = ST_MONITOR;
        end
      end
      ST_MONITOR: begin
        if (btnRel || !enS || !validS) begin
          nextState     = ST_PULSE;
          str.timerLoad = 1'b1;
          str.lenSel    = LEN_PULSE;
          str.countInc  = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (!lockS) begin
      nextState = ST_IDLE;
      str       = '0;
    end
    str.holdLow = (nextState == ST_IDLE) || (nextState == ST_PULSE);
  end

  always_ff @(posedge clk) state <= nextState;

  assign strobe = str;

  // R10
  lock_idle_chk: assert property (@(posedge clk)
    !lockS |=> (state == ST_IDLE));

  // R7
  holdoff_quiet_chk: assert property (@(posedge clk) disable iff (!lockS)
    (state == ST_HOLDOFF && !btnRel && !timerZero) |=> (state == ST_HOLDOFF));

  // R8
  burst_btn_chk: assert property (@(posedge clk) disable iff (!lockS)
    ((state == ST_SETTLE || state == ST_GAP) && btnRel && !timerZero)
      |=> (state == $past(state)));

endmodule

// File: rtl/brs_datapath.sv
module brs_datapath
  import boot_reset_pkg::*;
#(
  parameter int SETTLE_CYC  = 500_000_000,
  parameter int SPACING_CYC = 100_000_000,
  parameter int PULSE_CYC   = 16,
  parameter int BURST_NUM   = 15,
  parameter int HOLDOFF_CYC = 10_000_000,
  parameter int COUNT_W     = 16
) (
  input  logic               clk,
  input  logic               lockS,
  input  seqStrobe_t         strobe,
  output logic               timerZero,
  output logic               burstEmpty,
  output logic               doneFlag,
  output logic               rstN,
  output logic [COUNT_W-1:0] resetCount
);

  localparam int MAX_A   = (SETTLE_CYC > SPACING_CYC) ? SETTLE_CYC : SPACING_CYC;
  localparam int MAX_LEN = (MAX_A > HOLDOFF_CYC) ? MAX_A : HOLDOFF_CYC;
  localparam int TIMER_W = $clog2(MAX_LEN + 1);
  localparam int BURST_W = $clog2(BURST_NUM + 1);

  localparam logic [TIMER_W-1:0] SETTLE_LEN = TIMER_W'(SETTLE_CYC - 1);
  localparam logic [TIMER_W-1:0] PULSE_LEN  = TIMER_W'(PULSE_CYC - 1);
  localparam logic [TIMER_W-1:0] GAP_LEN    = TIMER_W'(SPACING_CYC - PULSE_CYC - 1);
  localparam logic [TIMER_W-1:0] HOLD_LEN   = TIMER_W'(HOLDOFF_CYC - 1);

  logic [TIMER_W-1:0] timer      = '0;
  logic [BURST_W-1:0] burstLeft  = '0;
  logic [COUNT_W-1:0] countReg   = '0;
  logic               rstNReg    = 1'b0;
  logic               doneReg    = 1'b0;
  logic [TIMER_W-1:0] loadValue;

  always_comb begin
    unique case (strobe.lenSel)
      LEN_SETTLE: loadValue = SETTLE_LEN;
      LEN_PULSE:  loadValue = PULSE_LEN;
      LEN_GAP:    loadValue = GAP_LEN;
      default:    loadValue = HOLD_LEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!lockS) begin
      timer     <= '0;
      burstLeft <= '0;
      doneReg   <= 1'b0;
    end else begin
      if (strobe.timerLoad)   timer <= loadValue;
      else if (timer != '0)   timer <= timer - 1'b1;
      if (strobe.burstLoad)     burstLeft <= BURST_W'(BURST_NUM);
      else if (strobe.burstDec) burstLeft <= burstLeft - 1'b1;
      if (strobe.doneSet)     doneReg <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    rstNReg <= !strobe.holdLow;
    if (strobe.countInc) countReg <= countReg + 1'b1;
  end

  assign timerZero  = (timer == '0);
  assign burstEmpty = (burstLeft == '0);
  assign doneFlag   = doneReg;
  assign rstN       = rstNReg;
  assign resetCount = countReg;

  // R4
  pulse_min_chk: assert property (@(posedge clk) disable iff (!lockS)
    $fell(rstNReg) |=> !rstNReg);

  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (!lockS)
    strobe.countInc |=> (!rstNReg && countReg != $past(countReg)));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!lockS)
    doneReg |=> doneReg);

  initial begin
    // R4
    pulse_width_param_chk: assert (PULSE_CYC >= 3 && SPACING_CYC > PULSE_CYC + 1);
  end

endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
  import boot_reset_pkg::*;
#(
  parameter int SETTLE_CYC  = 500_000_000,
  parameter int SPACING_CYC = 100_000_000,
  parameter int PULSE_CYC   = 16,
  parameter int BURST_NUM   = 15,
  parameter int HOLDOFF_CYC = 10_000_000,
  parameter int DEB_CYC     = 2_000_000,
  parameter int COUNT_W     = 16
) (
  input  logic               clk,
  input  logic               lockIn,
  input  logic               btnIn,
  input  logic               dacEnIn,
  input  logic               dataValidIn,
  output logic               rstN,
  output logic               seqDone,
  output logic [COUNT_W-1:0] resetCount
);

  logic [3:0] syncBus;
  logic       lockS, btnS, enS, validS;
  logic       btnLevel, btnRel;
  logic       timerZero, burstEmpty, doneFlag;
  seqStrobe_t strobe;

  brs_sync #(.WIDTH(4), .STAGES(2)) u_sync (
    .clk    (clk),
    .asyncIn({lockIn, btnIn, dacEnIn, dataValidIn}),
    .syncOut(syncBus)
  );

  assign {lockS, btnS, enS, validS} = syncBus;

  brs_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk         (clk),
    .enable      (lockS),
    .rawIn       (btnS),
    .level       (btnLevel),
    .releasePulse(btnRel)
  );

  brs_control u_ctrl (
    .clk       (clk),
    .lockS     (lockS),
    .enS       (enS),
    .validS    (validS),
    .btnRel    (btnRel),
    .timerZero (timerZero),
    .burstEmpty(burstEmpty),
    .doneFlag  (doneFlag),
    .strobe    (strobe)
  );

  brs_datapath #(
    .SETTLE_CYC (SETTLE_CYC),
    .SPACING_CYC(SPACING_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .BURST_NUM  (BURST_NUM),
    .HOLDOFF_CYC(HOLDOFF_CYC),
    .COUNT_W    (COUNT_W)
  ) u_dp (
    .clk       (clk),
    .lockS     (lockS),
    .strobe    (strobe),
    .timerZero (timerZero),
    .burstEmpty(burstEmpty),
    .doneFlag  (doneFlag),
    .rstN      (rstN),
    .resetCount(resetCount)
  );

  assign seqDone = doneFlag;

  // R8
  btn_level_chk: assert property (@(posedge clk) disable iff (!lockS)
    btnRel |-> !btnLevel);

endmodule

// File: tb/boot_reset_seq_bench.sv
module boot_reset_seq_bench;

  localparam int SETTLE  = 100;
  localparam int SPACING = 40;
  localparam int PULSE   = 5;
  localparam int BURST   = 3;
  localparam int HOLDOFF = 30;
  localparam int DEB     = 8;
  localparam int CW      = 8;
  localparam int LIMIT   = 20000;

  // {dacEn, dataValid, expected pulse count}
  localparam logic [2:0] WD_VEC [4] = '{3'b110, 3'b011, 3'b101, 3'b001};

  logic clk = 1'b0;
  logic lockIn = 1'b0, btnIn = 1'b0, dacEnIn = 1'b1, dataValidIn = 1'b1;
  logic rstN, seqDone;
  logic [CW-1:0] resetCount;

  int cyc = 0, nFalls = 0, lowStart = 0, minW = 1 << 20, maxW = 0;
  int starts [64];
  logic prevRst = 1'b0;
  int total = 0, failed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  boot_reset_seq #(
    .SETTLE_CYC(SETTLE), .SPACING_CYC(SPACING), .PULSE_CYC(PULSE),
    .BURST_NUM(BURST), .HOLDOFF_CYC(HOLDOFF), .DEB_CYC(DEB), .COUNT_W(CW)
  ) u_boot_reset_seq (
    .clk(clk), .lockIn(lockIn), .btnIn(btnIn), .dacEnIn(dacEnIn),
    .dataValidIn(dataValidIn), .rstN(rstN), .seqDone(seqDone),
    .resetCount(resetCount)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (prevRst && !rstN) begin
      starts[nFalls % 64] = cyc;
      nFalls   = nFalls + 1;
      lowStart = cyc;
    end
    if (!prevRst && rstN && nFalls > 0) begin
      if (cyc - lowStart < minW) minW = cyc - lowStart;
      if (cyc - lowStart > maxW) maxW = cyc - lowStart;
    end
    prevRst = rstN;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", cyc, LIMIT);
      summary();
      $finish;
    end
  end

  initial begin
    int lockCyc, n0, c0, spacingOk;
    // R1: no lock, nothing happens
    waitCyc(30);
    check(rstN == 1'b0, "R1 rstN low before lock", rstN, 0);
    check(seqDone == 1'b0, "R1 done low before lock", seqDone, 0);
    check(resetCount == '0 && nFalls == 0, "R1 no pulses before lock", resetCount, 0);

    // R2/R3/R4/R5/R8: startup burst with a button release in the gap
    lockIn  = 1'b1;
    lockCyc = cyc;
    wait (nFalls == 1);
    @(negedge clk);
    check(seqDone == 1'b0, "R5 done low during burst", seqDone, 0);
    btnIn = 1'b1;
    waitCyc(15);
    btnIn = 1'b0;
    waitCyc(BURST * SPACING + 20);
    check(starts[0] - lockCyc >= SETTLE && starts[0] - lockCyc <= SETTLE + 4,
          "R2 settle delay", starts[0] - lockCyc, SETTLE + 3);
    check(nFalls == BURST, "R3/R8 burst pulse count, release in gap ignored", nFalls, BURST);
    spacingOk = 1;
    for (int i = 1; i < BURST; i++)
      if (starts[i] - starts[i-1] != SPACING) spacingOk = 0;
    check(spacingOk == 1, "R3 burst pitch", starts[BURST-1] - starts[BURST-2], SPACING);
    check(minW == PULSE && maxW == PULSE, "R4 pulse width", minW, PULSE);
    check(seqDone == 1'b1, "R5 done after burst", seqDone, 1);
    check(int'(resetCount) == BURST, "R11 count after burst", resetCount, BURST);

    // R6: status watchdog vectors
    for (int i = 0; i < 4; i++) begin
      n0 = nFalls;
      dacEnIn     = WD_VEC[i][2];
      dataValidIn = WD_VEC[i][1];
      waitCyc(6);
      dacEnIn     = 1'b1;
      dataValidIn = 1'b1;
      waitCyc(100);
      check(nFalls - n0 == int'(WD_VEC[i][0]), "R6 status watchdog pulse", nFalls - n0, WD_VEC[i][0]);
    end

    // R7: flag held low, pulses paced by recovery interval
    n0 = nFalls;
    dataValidIn = 1'b0;
    wait (nFalls == n0 + 2);
    @(negedge clk);
    dataValidIn = 1'b1;
    check(starts[(n0+1) % 64] - starts[n0 % 64] >= PULSE + HOLDOFF, "R7 holdoff spacing",
          starts[(n0+1) % 64] - starts[n0 % 64], PULSE + HOLDOFF);
    waitCyc(80);

    // R8: button pulse on release only
    n0 = nFalls;
    btnIn = 1'b1;
    waitCyc(25);
    check(nFalls == n0, "R8 no pulse while held", nFalls - n0, 0);
    btnIn = 1'b0;
    waitCyc(20);
    check(nFalls == n0 + 1, "R8 pulse after release", nFalls - n0, 1);
    waitCyc(50);

    // R9: short glitch ignored
    n0 = nFalls;
    btnIn = 1'b1;
    waitCyc(3);
    btnIn = 1'b0;
    waitCyc(40);
    check(nFalls == n0, "R9 glitch ignored", nFalls - n0, 0);
    check(int'(resetCount) == nFalls, "R11 count matches pulses", resetCount, nFalls);

    // R10: lock loss and restart
    c0 = int'(resetCount);
    lockIn = 1'b0;
    waitCyc(4);
    check(rstN == 1'b0, "R10 rstN low on lock loss", rstN, 0);
    check(seqDone == 1'b0, "R10 done low on lock loss", seqDone, 0);
    check(int'(resetCount) == c0, "R11 lock hold not counted", resetCount, c0);
    lockIn = 1'b1;
    waitCyc(SETTLE + BURST * SPACING + 20);
    check(int'(resetCount) - c0 == BURST, "R10 full burst after relock", int'(resetCount) - c0, BURST);
    check(seqDone == 1'b1, "R10 done after relock burst", seqDone, 1);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule